// File: doc/BRIEF.md
# Block-Linear Surface Address Generator

This block turns a byte column and a line number into a byte offset inside a block-linear surface. The surface is tiled with 64-byte by 8-line tiles of 512 bytes. A power-of-two number of these tiles is stacked vertically to form one block. Blocks run left to right across a block row, and block rows follow one another down the surface. Inside a tile, bytes are grouped into 16-byte by 2-line sectors. Each sector is row-major, and the sectors are laid out in Z order.

A requester presents a coordinate pair, the surface width in blocks and the log2 of the tiles per block on a valid/ready handshake. One cycle after acceptance the block presents the offset on a second valid/ready handshake. A walk request returns the offsets of a rectangle instead. Its origin is the request coordinate, its columns are spaced 16 bytes apart, and it is emitted row by row. The final offset of each request carries a last flag. A stacking exponent above 5 cannot be served: the block answers with a single error response.

Top module: `gobswz_top`

## Requirements
- R1: After reset, rsp_valid is 0 and req_ready is 1.
- R2: Offset bits [3:0] equal x[3:0], bit 4 equals y[0], bit 5 equals x[4], bit 6 equals y[1], bit 7 equals x[5] and bit 8 equals y[2].
- R3: Within a block, the tile index (y/8) mod 2^v adds index*512 to the offset.
- R4: The block index (y/(8*2^v))*width + x/64 adds index*(512*2^v) to the offset.
- R5: A request with req_log2h greater than 5 produces exactly one response, with rsp_err=1, rsp_offset=0 and rsp_last=1. This holds even when req_scan is 1.
- R6: The first response of an accepted request is valid in the cycle after acceptance.
- R7: While rsp_valid is 1 and rsp_ready is 0, rsp_offset, rsp_err and rsp_last hold their values and rsp_valid stays 1.
- R8: With req_scan=1, the block emits (req_rows+1)*(req_cols+1) offsets. Columns step x by 16, the row advances after the last column, and only the final offset has rsp_last=1. req_ready is 0 while the walk is still in progress.
- R9: With req_scan=0, req_cols and req_rows are ignored, and the block emits a single response with rsp_last=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_scan | input | 1 | 1 = walk a rectangle, 0 = single point |
| req_x | input | 16 | Byte column |
| req_y | input | 16 | Line |
| req_cols | input | 10 | Extra columns to walk (count minus one) |
| req_rows | input | 10 | Extra rows to walk (count minus one) |
| req_width_blk | input | 10 | Surface width in blocks |
| req_log2h | input | 4 | log2 of tiles stacked per block |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_offset | output | 48 | Byte offset |
| rsp_err | output | 1 | Stacking exponent out of range |
| rsp_last | output | 1 | Final response of the request |

## Verification
Single points are swept so that each coordinate bit moves on its own. This separates a wrong Z interleave inside a tile from a wrong tile-in-block term and from a wrong block-column or block-row term. Every exponent from 0 to 5 is tried at block boundaries, where a mistaken shift amount shows up at once. Walks that cross a block edge check the row-major order and the placement of the last flag. Stretches of stalled responses show whether output is held and whether the walk resumes without skipping or repeating a point. Out-of-range exponents, alone and combined with a walk, show that exactly one error response is produced.

// File: rtl/gobswz_pkg.sv
package gobswz_pkg;
    // tile geometry
    localparam int TILE_W_LOG2    = 6;
    localparam int TILE_H_LOG2    = 3;
    localparam int TILE_BYTES_LOG2 = TILE_W_LOG2 + TILE_H_LOG2;
    localparam int SECT_W_LOG2    = 4;
    // stacking exponent
    localparam int LOG2H_W        = 4;
    localparam int LOG2H_MAX      = 5;
endpackage

// File: rtl/gobswz_intra.sv
// Byte position inside one 512-byte tile: row-major 16x2 sectors in Z order.
module gobswz_intra
    import gobswz_pkg::*;
(
    input  logic [TILE_W_LOG2-1:0]     x_lo,
    input  logic [TILE_H_LOG2-1:0]     y_lo,
    output logic [TILE_BYTES_LOG2-1:0] off
);
    localparam int ZPAIRS = TILE_H_LOG2;

    assign off[SECT_W_LOG2-1:0] = x_lo[SECT_W_LOG2-1:0];

    // alternate line bit and column bit, line bit first
    for (genvar k = 0; k < ZPAIRS; k++) begin : g_z
        assign off[SECT_W_LOG2 + 2*k] = y_lo[k];
        if (SECT_W_LOG2 + k < TILE_W_LOG2) begin : g_xbit
            assign off[SECT_W_LOG2 + 2*k + 1] = x_lo[SECT_W_LOG2 + k];
        end
    end
endmodule

// File: rtl/gobswz_place.sv
// Tile-in-block and block placement part of the offset.
module gobswz_place
    import gobswz_pkg::*;
#(
    parameter int X_W   = 16,
    parameter int Y_W   = 16,
    parameter int WB_W  = 10,
    parameter int OFF_W = 48
) (
    input  logic [X_W-1:0]     x,
    input  logic [Y_W-1:0]     y,
    input  logic [WB_W-1:0]    width_blk,
    input  logic [LOG2H_W-1:0] log2h,
    output logic [OFF_W-1:0]   coarse
);
    localparam int SH_W = 5;

    logic [SH_W-1:0]  row_sh;
    logic [SH_W-1:0]  blk_sh;
    logic [Y_W-1:0]   tile_row;
    logic [Y_W-1:0]   stack_mask;
    logic [Y_W-1:0]   tile_sel;
    logic [Y_W-1:0]   blk_row;
    logic [OFF_W-1:0] blk_idx;

    always_comb begin
        row_sh     = SH_W'(TILE_H_LOG2) + SH_W'(log2h);
        blk_sh     = SH_W'(TILE_BYTES_LOG2) + SH_W'(log2h);
        tile_row   = y >> TILE_H_LOG2;
        stack_mask = (Y_W'(1) << log2h) - Y_W'(1);
        tile_sel   = tile_row & stack_mask;
        blk_row    = y >> row_sh;
        blk_idx    = OFF_W'(blk_row) * OFF_W'(width_blk) + OFF_W'(x >> TILE_W_LOG2);
        coarse     = (blk_idx << blk_sh) + (OFF_W'(tile_sel) << TILE_BYTES_LOG2);
    end
endmodule

// File: rtl/gobswz_top.sv
module gobswz_top
    import gobswz_pkg::*;
#(
    parameter int X_W       = 16,
    parameter int Y_W       = 16,
    parameter int CNT_W     = 10,
    parameter int WB_W      = 10,
    parameter int OFF_W     = 48,
    parameter int STEP_LOG2 = SECT_W_LOG2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_scan,
    input  logic [X_W-1:0]     req_x,
    input  logic [Y_W-1:0]     req_y,
    input  logic [CNT_W-1:0]   req_cols,
    input  logic [CNT_W-1:0]   req_rows,
    input  logic [WB_W-1:0]    req_width_blk,
    input  logic [LOG2H_W-1:0] req_log2h,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [OFF_W-1:0]   rsp_offset,
    output logic               rsp_err,
    output logic               rsp_last
);
    localparam logic [X_W-1:0] STEP = X_W'(1) << STEP_LOG2;

    typedef struct packed {
        logic               busy;
        logic [X_W-1:0]     cur_x;
        logic [Y_W-1:0]     cur_y;
        logic [X_W-1:0]     base_x;
        logic [CNT_W-1:0]   col;
        logic [CNT_W-1:0]   row;
        logic [CNT_W-1:0]   cols;
        logic [CNT_W-1:0]   rows;
        logic [WB_W-1:0]    width;
        logic [LOG2H_W-1:0] log2h;
        logic               rv;
        logic [OFF_W-1:0]   roff;
        logic               rerr;
        logic               rlast;
    } st_t;

    st_t st_d, st_q;

    logic               out_free;
    logic               accept;
    logic               bad_log2h;
    logic [X_W-1:0]     sel_x, sel_base, nxt_x;
    logic [Y_W-1:0]     sel_y, nxt_y;
    logic [CNT_W-1:0]   sel_col, sel_row, sel_cols, sel_rows, nxt_col, nxt_row;
    logic [WB_W-1:0]    sel_w;
    logic [LOG2H_W-1:0] sel_v;
    logic               is_final;
    logic [TILE_BYTES_LOG2-1:0] fine_off;
    logic [OFF_W-1:0]   coarse_off;
    logic [OFF_W-1:0]   point_off;

    // point selection: stored walk position or the incoming request
    always_comb begin
        if (st_q.busy) begin
            sel_x    = st_q.cur_x;
            sel_y    = st_q.cur_y;
            sel_base = st_q.base_x;
            sel_col  = st_q.col;
            sel_row  = st_q.row;
            sel_cols = st_q.cols;
            sel_rows = st_q.rows;
            sel_w    = st_q.width;
            sel_v    = st_q.log2h;
        end else begin
            sel_x    = req_x;
            sel_y    = req_y;
            sel_base = req_x;
            sel_col  = '0;
            sel_row  = '0;
            sel_cols = req_scan ? req_cols : '0;
            sel_rows = req_scan ? req_rows : '0;
            sel_w    = req_width_blk;
            sel_v    = req_log2h;
        end
    end

    gobswz_intra u_intra (
        .x_lo (sel_x[TILE_W_LOG2-1:0]),
        .y_lo (sel_y[TILE_H_LOG2-1:0]),
        .off  (fine_off)
    );

    gobswz_place #(
        .X_W   (X_W),
        .Y_W   (Y_W),
        .WB_W  (WB_W),
        .OFF_W (OFF_W)
    ) u_place (
        .x         (sel_x),
        .y         (sel_y),
        .width_blk (sel_w),
        .log2h     (sel_v),
        .coarse    (coarse_off)
    );

    assign point_off = coarse_off + OFF_W'(fine_off);

    // walk order: columns inner, rows outer
    always_comb begin
        is_final = (sel_col == sel_cols) && (sel_row == sel_rows);
        if (sel_col == sel_cols) begin
            nxt_x   = sel_base;
            nxt_y   = sel_y + Y_W'(1);
            nxt_col = '0;
            nxt_row = sel_row + CNT_W'(1);
        end else begin
            nxt_x   = sel_x + STEP;
            nxt_y   = sel_y;
            nxt_col = sel_col + CNT_W'(1);
            nxt_row = sel_row;
        end
    end

    assign out_free  = !st_q.rv || rsp_ready;
    assign req_ready = !st_q.busy && out_free;
    assign accept    = req_valid && req_ready;
    assign bad_log2h = req_log2h > LOG2H_W'(LOG2H_MAX);

    always_comb begin
        st_d = st_q;
        if (out_free) begin
            st_d.rv = 1'b0;
            if (st_q.busy || (accept && !bad_log2h)) begin
                st_d.rv     = 1'b1;
                st_d.roff   = point_off;
                st_d.rerr   = 1'b0;
                st_d.rlast  = is_final;
                st_d.busy   = !is_final;
                st_d.cur_x  = nxt_x;
                st_d.cur_y  = nxt_y;
                st_d.col    = nxt_col;
                st_d.row    = nxt_row;
                st_d.base_x = sel_base;
                st_d.cols   = sel_cols;
                st_d.rows   = sel_rows;
                st_d.width  = sel_w;
                st_d.log2h  = sel_v;
            end else if (accept) begin
                st_d.rv    = 1'b1;
                st_d.roff  = '0;
                st_d.rerr  = 1'b1;
                st_d.rlast = 1'b1;
                st_d.busy  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid  = st_q.rv;
    assign rsp_offset = st_q.roff;
    assign rsp_err    = st_q.rerr;
    assign rsp_last   = st_q.rlast;

    // R7
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_offset)
                                    && $stable(rsp_err) && $stable(rsp_last));

    // R6
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> rsp_valid);

    // R5
    bad_log2h_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (req_log2h > LOG2H_W'(LOG2H_MAX))
        |=> rsp_err && rsp_last && (rsp_offset == '0));

    // R9
    single_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_scan |=> rsp_last);

    // R2
    sector_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !bad_log2h
        |=> rsp_offset[SECT_W_LOG2-1:0] == $past(req_x[SECT_W_LOG2-1:0]));
endmodule

// File: tb/gobswz_top_test.sv
`timescale 1ns/1ps
module gobswz_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_scan = 1'b0;
    logic [15:0] req_x = '0;
    logic [15:0] req_y = '0;
    logic [9:0]  req_cols = '0;
    logic [9:0]  req_rows = '0;
    logic [9:0]  req_width_blk = '0;
    logic [3:0]  req_log2h = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [47:0] rsp_offset;
    logic        rsp_err;
    logic        rsp_last;

    always #2.5 clk = ~clk;

    gobswz_top uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_scan(req_scan),
        .req_x(req_x), .req_y(req_y), .req_cols(req_cols), .req_rows(req_rows),
        .req_width_blk(req_width_blk), .req_log2h(req_log2h),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_offset(rsp_offset),
        .rsp_err(rsp_err), .rsp_last(rsp_last)
    );

    typedef struct {
        longint unsigned off;
        bit              err;
        bit              last;
        string           tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   bp_mode = 1'b0;
    int   bp_cnt = 0;
    string cur_tag = "R4";
    bit   done = 1'b0;

    function automatic longint unsigned ref_off(int x, int y, int wb, int v);
        longint unsigned fine, tile, blk;
        fine = longint'(x % 16)
             + longint'(y % 2) * 16
             + longint'((x / 16) % 2) * 32
             + longint'((y / 2) % 2) * 64
             + longint'((x / 32) % 2) * 128
             + longint'((y / 4) % 2) * 256;
        tile = longint'((y / 8) % (1 << v));
        blk  = longint'(y / (8 << v)) * longint'(wb) + longint'(x / 64);
        return blk * (longint'(512) << v) + tile * 512 + fine;
    endfunction

    task automatic check(bit ok, string tag, string what, longint unsigned act, longint unsigned exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push_req();
        exp_t e;
        int cols, rows;
        if (req_log2h > 5) begin
            e.off = 0; e.err = 1; e.last = 1; e.tag = "R5";
            exp_q.push_back(e);
            return;
        end
        cols = req_scan ? int'(req_cols) : 0;
        rows = req_scan ? int'(req_rows) : 0;
        for (int r = 0; r <= rows; r++) begin
            for (int c = 0; c <= cols; c++) begin
                e.off  = ref_off((int'(req_x) + c * 16) % 65536, (int'(req_y) + r) % 65536,
                                 int'(req_width_blk), int'(req_log2h));
                e.err  = 0;
                e.last = (r == rows) && (c == cols);
                e.tag  = cur_tag;
                exp_q.push_back(e);
            end
        end
    endtask

    // backpressure pattern
    always @(negedge clk) begin
        bp_cnt++;
        rsp_ready = bp_mode ? ((bp_cnt % 3) != 0) : 1'b1;
    end

    // reference comparison every cycle
    bit              prev_acc = 0;
    bit              prev_hold = 0;
    logic [47:0]     prev_off = '0;
    always @(negedge clk) begin
        exp_t e;
        #1;
        if (rst_n && !done) begin
            if (prev_acc)
                check(rsp_valid === 1'b1, "R6", "response one cycle after accept", rsp_valid, 1);
            if (prev_hold)
                check(rsp_valid === 1'b1 && rsp_offset === prev_off, "R7",
                      "held response", rsp_offset, prev_off);
            if (rsp_valid && rsp_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8", "unexpected response", rsp_offset, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(rsp_offset === e.off, e.tag, "offset", rsp_offset, e.off);
                    check(rsp_err === e.err, e.tag, "err flag", rsp_err, e.err);
                    check(rsp_last === e.last, e.tag, "last flag", rsp_last, e.last);
                end
            end
            prev_acc  = req_valid && req_ready;
            if (req_valid && req_ready) push_req();
            prev_hold = rsp_valid && !rsp_ready;
            prev_off  = rsp_offset;
        end
    end

    task automatic send(string tag, bit scan, int x, int y, int cols, int rows, int wb, int v);
        @(negedge clk);
        cur_tag       = tag;
        req_scan      = scan;
        req_x         = 16'(x);
        req_y         = 16'(y);
        req_cols      = 10'(cols);
        req_rows      = 10'(rows);
        req_width_blk = 10'(wb);
        req_log2h     = 4'(v);
        req_valid     = 1'b1;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && (exp_q.size() != 0 || rsp_valid); i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check(rsp_valid === 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
        check(req_ready === 1'b1, "R1", "req_ready in reset", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(rsp_valid === 1'b0 && req_ready === 1'b1, "R1", "idle after reset", rsp_valid, 0);

        // R2: each bit inside one tile
        send("R2", 0, 0, 0, 0, 0, 4, 0);
        for (int b = 0; b < 6; b++) send("R2", 0, 1 << b, 0, 0, 0, 4, 0);
        for (int b = 0; b < 3; b++) send("R2", 0, 0, 1 << b, 0, 0, 4, 0);
        send("R2", 0, 63, 7, 0, 0, 4, 0);
        // R3: tile stacking inside a block
        for (int v = 0; v <= 5; v++) begin
            send("R3", 0, 5, 8, 0, 0, 3, v);
            send("R3", 0, 40, (8 << v) - 1, 0, 0, 3, v);
        end
        // R4: block placement and block-row boundaries
        for (int v = 0; v <= 5; v++) begin
            send("R4", 0, 64, 0, 0, 0, 3, v);
            send("R4", 0, 130, 8 << v, 0, 0, 3, v);
            send("R4", 0, 700, 1000, 0, 0, 17, v);
        end
        drain();
        // R5: out-of-range exponent, alone and as a walk
        send("R5", 0, 100, 20, 0, 0, 2, 6);
        send("R5", 1, 100, 20, 3, 2, 2, 15);
        drain();
        // R9: counts ignored without the walk flag
        send("R9", 0, 17, 9, 5, 4, 2, 1);
        drain();
        // R8: walks, including block edge crossing
        send("R8", 1, 0, 0, 3, 1, 2, 2);
        #1;
        check(req_ready === 1'b0, "R8", "busy during walk", req_ready, 0);
        drain();
        send("R8", 1, 32, 6, 4, 0, 3, 0);
        send("R8", 1, 48, 14, 0, 3, 2, 1);
        drain();
        // R7: stalls during walks and singles
        bp_mode = 1'b1;
        send("R7", 1, 16, 3, 5, 2, 4, 3);
        send("R7", 0, 200, 300, 0, 0, 6, 4);
        send("R7", 0, 99, 77, 0, 0, 5, 7);
        send("R7", 1, 0, 60, 2, 2, 2, 5);
        drain();
        bp_mode = 1'b0;
        drain();
        check(exp_q.size() == 0, "R8", "pending responses", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule